// File: doc/BRIEF.md
# Reset-Time Registered Bypass Transceiver

While the device-level reset input is held low, this block turns a bidirectional FIFO's two ports into a registered transceiver. Port A is the master. On a qualified port A clock edge, the port A read/write input sets the direction. A write moves a word from the A-side data bus into a register that drives the B side. A read moves a word from the B-side bus into a register that drives the A side. Port B has no controls in this mode and cannot start a transfer.

The block also qualifies the reset itself. A reset counts as taken only if both port clocks each show at least one rising edge and one falling edge while reset is low. A `ready` output rises after the reset is released, and only when that qualification completed during the reset. The rest of the chip therefore sees no FIFO traffic before a proper reset.

All logic runs on one core clock. The reset input and both port clocks pass through `SYNC_STAGES` flip-flop synchronizers, and the port clock edges are detected in the core clock domain. The flip-flops use a separate power-on reset. The device reset input is a functional signal, and the block must keep running while it is low.

Top module: `reset_bypass_xcvr`

## Requirements
- R1: `bypass` is 1 within SYNC_STAGES+1 core cycles of `rst_n` going low, and 0 within SYNC_STAGES+1 core cycles of `rst_n` going high.
- R2: In bypass, a port A clock rising edge with `a_en`=1, `a_req`=1 and `a_rw`=0 stores `a_din`. Within SYNC_STAGES+2 core cycles, `b_dout` shows that word with `b_drive`=1 and `a_drive`=0.
- R3: In bypass, the same edge with `a_rw`=1 stores `b_din`. `a_dout` then shows that word with `a_drive`=1 and `b_drive`=0.
- R4: A port A clock edge with `a_en`=0 or `a_req`=0 changes neither data output nor either drive flag.
- R5: A stored word stays on its destination output until the next transfer in the same direction. A transfer in the other direction leaves it unchanged and moves the drive flag.
- R6: With `rst_n` high, no port A edge changes the data outputs, and `a_drive`=`b_drive`=0.
- R7: After the power-on reset `ready` is 0. It stays 0 until the first qualified reset is released.
- R8: A qualified reset pulls `ready` to 0 while `rst_n` is low. `ready` returns to 1 within SYNC_STAGES+2 core cycles of release. A reset is qualified when `ck_a` and `ck_b` each rise and fall while `rst_n` is low.
- R9: A reset low phase that lacks any one of the four clock edges leaves `ready` unchanged, both during the reset and after it.
- R10: `a_drive` and `b_drive` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_n | input | 1 | Device reset input, active low; low selects bypass |
| ck_a | input | 1 | Port A clock, sampled by the core clock |
| ck_b | input | 1 | Port B clock, sampled by the core clock |
| a_en | input | 1 | Port A enable |
| a_req | input | 1 | Port A request |
| a_rw | input | 1 | Port A direction: 0 A to B, 1 B to A |
| a_din | input | WIDTH | A-side input bus |
| b_din | input | WIDTH | B-side input bus |
| a_dout | output | WIDTH | Registered word for the A side |
| a_drive | output | 1 | A side should be driven |
| b_dout | output | WIDTH | Registered word for the B side |
| b_drive | output | 1 | B side should be driven |
| bypass | output | 1 | Bypass mode active |
| ready | output | 1 | Qualified reset completed and released |

## Verification
The assertions check every cycle that:
- a qualifying port A edge loads the correct register and direction;
- any other cycle leaves both data registers untouched;
- the direction returns to idle once bypass ends;
- `ready` rises only after all four clock edges were seen and falls only inside a reset.

Only the bench scenarios can show three things:
- that the synchronizer latency lands inside the stated windows;
- that a short or one-sided reset truly leaves `ready` alone;
- that the whole sequence from power-on through bypass traffic to a qualified release produces the expected words on the expected side.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_A2B  = 2'd1,
    DIR_B2A  = 2'd2
  } dir_e;
endpackage

// File: rtl/rbx_sync.sv
// Multi-bit, multi-stage synchronizer; every bit is independent.
module rbx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stg_q[g] <= '0;
        else if (g == 0) stg_q[g] <= d;
        else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rbx_qual.sv
// Clock-edge detection and reset qualification in the core clock domain.
module rbx_qual (
  input  logic clk,
  input  logic por_n,
  input  logic rs_s,     // synchronized device reset, active low
  input  logic cka_s,
  input  logic ckb_s,
  output logic cka_rise,
  output logic bypass,
  output logic ready
);
  logic       cka_prev_q, ckb_prev_q;
  logic       rs_prev_q, rs_prev_d;
  logic [3:0] seen_q, seen_d;
  logic       ready_q, ready_d;
  logic       cka_fall, ckb_rise, ckb_fall;
  logic       qual_done, release_edge;

  assign cka_rise = cka_s & ~cka_prev_q;
  assign cka_fall = ~cka_s & cka_prev_q;
  assign ckb_rise = ckb_s & ~ckb_prev_q;
  assign ckb_fall = ~ckb_s & ckb_prev_q;

  assign qual_done    = &seen_q;
  assign release_edge = rs_s & ~rs_prev_q;

  always_comb begin
    rs_prev_d = rs_s;
    if (rs_s) seen_d = '0;
    else      seen_d = seen_q | {ckb_fall, ckb_rise, cka_fall, cka_rise};
    ready_d = ready_q;
    if (release_edge && qual_done)  ready_d = 1'b1;
    else if (!rs_s && qual_done)    ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cka_prev_q <= 1'b0;
      ckb_prev_q <= 1'b0;
      rs_prev_q  <= 1'b0;
      seen_q     <= '0;
      ready_q    <= 1'b0;
    end else begin
      cka_prev_q <= cka_s;
      ckb_prev_q <= ckb_s;
      rs_prev_q  <= rs_prev_d;
      seen_q     <= seen_d;
      ready_q    <= ready_d;
    end
  end

  assign bypass = ~rs_s;
  assign ready  = ready_q;

  // R8: ready only rises once all four clock edges were recorded
  a_r8_rise_needs_qual: assert property (@(posedge clk) disable iff (!por_n)
    $rose(ready_q) |-> $past(seen_q) == 4'hF);
  // R9: ready only drops while the device reset is held
  a_r9_fall_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    $fell(ready_q) |-> !$past(rs_s));
endmodule

// File: rtl/rbx_path.sv
// Port-A-controlled registered bypass data path.
module rbx_path
  import rbx_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             byp,
  input  logic             edge_a,
  input  logic             a_en,
  input  logic             a_req,
  input  logic             a_rw,
  input  logic [WIDTH-1:0] a_din,
  input  logic [WIDTH-1:0] b_din,
  output logic [WIDTH-1:0] a_dout,
  output logic [WIDTH-1:0] b_dout,
  output logic             a_drive,
  output logic             b_drive
);
  logic [WIDTH-1:0] a_q, a_d, b_q, b_d;
  dir_e             dir_q, dir_d;
  logic             xfer;

  assign xfer = byp & edge_a & a_en & a_req;

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    dir_d = dir_q;
    if (!byp) begin
      dir_d = DIR_NONE;
    end else if (xfer) begin
      if (a_rw) begin
        a_d   = b_din;
        dir_d = DIR_B2A;
      end else begin
        b_d   = a_din;
        dir_d = DIR_A2B;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      a_q   <= '0;
      b_q   <= '0;
      dir_q <= DIR_NONE;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      dir_q <= dir_d;
    end
  end

  assign a_dout  = a_q;
  assign b_dout  = b_q;
  assign a_drive = (dir_q == DIR_B2A);
  assign b_drive = (dir_q == DIR_A2B);

  // R2: a write edge loads the B-side register and points the drive at B
  a_r2_a_to_b: assert property (@(posedge clk) disable iff (!por_n)
    (xfer && !a_rw) |=> (b_q == $past(a_din)) && (dir_q == DIR_A2B));
  // R3: a read edge loads the A-side register and points the drive at A
  a_r3_b_to_a: assert property (@(posedge clk) disable iff (!por_n)
    (xfer && a_rw) |=> (a_q == $past(b_din)) && (dir_q == DIR_B2A));
  // R4/R5: without a qualifying edge both registers hold
  a_r4_hold: assert property (@(posedge clk) disable iff (!por_n)
    !xfer |=> $stable(a_q) && $stable(b_q));
  // R6: leaving bypass idles the direction
  a_r6_idle_outside: assert property (@(posedge clk) disable iff (!por_n)
    !byp |=> dir_q == DIR_NONE);
endmodule

// File: rtl/reset_bypass_xcvr.sv
module reset_bypass_xcvr #(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             ck_a,
  input  logic             ck_b,
  input  logic             a_en,
  input  logic             a_req,
  input  logic             a_rw,
  input  logic [WIDTH-1:0] a_din,
  input  logic [WIDTH-1:0] b_din,
  output logic [WIDTH-1:0] a_dout,
  output logic             a_drive,
  output logic [WIDTH-1:0] b_dout,
  output logic             b_drive,
  output logic             bypass,
  output logic             ready
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, syncd;
  logic             cka_rise;

  assign raw_in = {rst_n, ck_b, ck_a};

  rbx_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_n(por_n), .d(raw_in), .q(syncd)
  );

  rbx_qual u_qual (
    .clk(clk), .por_n(por_n), .rs_s(syncd[2]), .cka_s(syncd[0]),
    .ckb_s(syncd[1]), .cka_rise(cka_rise), .bypass(bypass), .ready(ready)
  );

  rbx_path #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .por_n(por_n), .byp(bypass), .edge_a(cka_rise),
    .a_en(a_en), .a_req(a_req), .a_rw(a_rw), .a_din(a_din), .b_din(b_din),
    .a_dout(a_dout), .b_dout(b_dout), .a_drive(a_drive), .b_drive(b_drive)
  );
endmodule

// File: tb/reset_bypass_xcvr_bench.sv
module reset_bypass_xcvr_bench;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         por_n, rst_n, ck_a, ck_b, a_en, a_req, a_rw;
  logic [W-1:0] a_din, b_din, a_dout, b_dout;
  logic         a_drive, b_drive, bypass, ready;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // expected-state scoreboard: 0 none, 1 A to B, 2 B to A
  logic [W-1:0] m_a = '0, m_b = '0;
  int           m_dir = 0;
  logic [W-1:0] qa[$], qb[$];
  int           qd[$];
  event         sample_ev;

  always #2.5 clk = ~clk;

  reset_bypass_xcvr #(.WIDTH(W), .SYNC_STAGES(2)) u_reset_bypass_xcvr (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ck_a(ck_a), .ck_b(ck_b),
    .a_en(a_en), .a_req(a_req), .a_rw(a_rw), .a_din(a_din), .b_din(b_din),
    .a_dout(a_dout), .a_drive(a_drive), .b_dout(b_dout), .b_drive(b_drive),
    .bypass(bypass), .ready(ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_expect();
    qa.push_back(m_a);
    qb.push_back(m_b);
    qd.push_back(m_dir);
    ->sample_ev;
  endtask

  // one full port A clock cycle; the model is updated per the requirements
  task automatic port_a_cycle(input logic en, input logic req, input logic rw,
                              input logic [W-1:0] ad, input logic [W-1:0] bd,
                              input logic in_reset);
    @(negedge clk);
    a_en = en; a_req = req; a_rw = rw; a_din = ad; b_din = bd;
    wait_cyc(1);
    ck_a = 1'b1;
    wait_cyc(5);
    ck_a = 1'b0;
    wait_cyc(5);
    if (in_reset && en && req) begin
      if (rw) begin m_a = bd; m_dir = 2; end
      else    begin m_b = ad; m_dir = 1; end
    end
    push_expect();
    wait_cyc(1);
  endtask

  task automatic pulse_b();
    @(negedge clk); ck_b = 1'b1;
    wait_cyc(5);    ck_b = 1'b0;
    wait_cyc(5);
  endtask

  // monitor: pops expectations and compares with the outputs
  initial begin
    forever begin
      @(sample_ev);
      #0;
      if (qd.size() > 0) begin
        automatic logic [W-1:0] ea = qa.pop_front();
        automatic logic [W-1:0] eb = qb.pop_front();
        automatic int           ed = qd.pop_front();
        chk("R2/R5 b_dout", 64'(b_dout), 64'(eb));
        chk("R3/R5 a_dout", 64'(a_dout), 64'(ea));
        chk("R2/R6 b_drive", 64'(b_drive), 64'(ed == 1));
        chk("R3/R6 a_drive", 64'(a_drive), 64'(ed == 2));
        chk("R10 single driver", 64'(a_drive & b_drive), 64'd0);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; ck_a = 1'b0; ck_b = 1'b0;
    a_en = 1'b0; a_req = 1'b0; a_rw = 1'b0; a_din = '0; b_din = '0;
    wait_cyc(3);
    por_n = 1'b1;
    wait_cyc(4);
    chk("R7 ready after power-on", 64'(ready), 64'd0);
    chk("R1 bypass while rst_n low", 64'(bypass), 64'd1);
    push_expect();
    wait_cyc(1);

    // bypass traffic; R2, R3, R4, R5
    port_a_cycle(1, 1, 0, 36'h9_1234_5678, 36'h0_0000_0001, 1);
    pulse_b();
    port_a_cycle(1, 1, 1, 36'h0_AAAA_0000, 36'hF_0F0F_0F0F, 1);
    port_a_cycle(0, 1, 0, 36'h5_5555_5555, 36'h3_3333_3333, 1); // R4 en low
    port_a_cycle(1, 0, 1, 36'h6_6666_6666, 36'h7_7777_7777, 1); // R4 req low
    port_a_cycle(1, 1, 0, 36'hA_BCDE_F012, 36'h1_1111_1111, 1);
    chk("R7 ready still low inside reset", 64'(ready), 64'd0);

    // qualified release; R1, R8
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(5);
    chk("R8 ready after qualified release", 64'(ready), 64'd1);
    chk("R1 bypass ends", 64'(bypass), 64'd0);
    m_dir = 0;
    push_expect();
    wait_cyc(1);

    // traffic outside reset is ignored; R6
    port_a_cycle(1, 1, 0, 36'h2_2222_2222, 36'h4_4444_4444, 0);
    port_a_cycle(1, 1, 1, 36'h2_2222_2222, 36'h4_4444_4444, 0);

    // short reset, no clock edges; R9
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(6);
    chk("R1 bypass re-entered", 64'(bypass), 64'd1);
    chk("R9 ready held in short reset", 64'(ready), 64'd1);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(6);
    chk("R9 ready after short reset", 64'(ready), 64'd1);

    // reset with only port A toggling; R9
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(4);
    port_a_cycle(0, 0, 0, '0, '0, 1);
    chk("R9 ready held, port B idle", 64'(ready), 64'd1);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(6);
    chk("R9 ready after one-sided reset", 64'(ready), 64'd1);

    // fully qualified reset; R8, with a B-to-A transfer inside
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(4);
    pulse_b();
    port_a_cycle(1, 1, 1, 36'h0_0000_0000, 36'hC_0FFE_E123, 1);
    wait_cyc(2);
    chk("R8 ready low in qualified reset", 64'(ready), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(5);
    chk("R8 ready back after release", 64'(ready), 64'd1);
    m_dir = 0;
    push_expect();
    wait_cyc(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule